// File: doc/BRIEF.md
# Secure Configuration Register Block for a Memory Protection Filter

This block holds the configuration state that a memory protection filter needs to decide, block by block, whether a secure or a non-secure transaction may reach the protected memory. It has a 32-bit control word and a block-index pointer. It also has a security lookup table (LUT) with one bit per memory block, packed into 32-bit words. The filter reads the whole table at once through a flat output bus. Software reaches the table one word at a time through an indirect window. The window selects its word with the index pointer, and the pointer can step forward by itself after each full-word access.

The register port is a plain request port with no handshake. A request is taken on every clock edge where `req` is high, and there are no wait states. Read data is registered: it appears on `rd_data` in the cycle after the request and holds until the next read request. Each request carries an access size and a secure attribute. Non-secure requests can see only the identification area. A one-way lockdown bit freezes the control word and the LUT until the next reset. The lockdown state is also exported, so that a neighbouring interrupt block can freeze its own enable register.

Top module: `secfilt_cfg_regs`

## Requirements
- R1: After reset, control reads 0x00000100, the index reads 0, every LUT word is zero, `lut_bits` is zero, `rd_data` is zero, and both `err_resp_en` and `locked` are low.
- R2: Control (offset 0x000) keeps only bit 4 (error-response select, driven on `err_resp_en`), bit 8 (auto-increment) and bit 31 (lockdown, driven on `locked`). All other bits read as zero.
- R3: Offset 0x010 reads the LUT word count, ceil(NUM_BLOCKS/32). Offset 0x014 reads BLOCK_LOG2-5. Writes to either offset have no effect.
- R4: A write to the index (offset 0x018) stores the written value modulo the LUT word count.
- R5: Offset 0x01C reads and writes the LUT word selected by the index. Word i appears on `lut_bits[32*i +: 32]` in the cycle after it is written.
- R6: With auto-increment set, a full-word secure access to 0x01C advances the index, and the index wraps from the last word to 0. A byte or halfword access does not advance it, and neither does any access while auto-increment is clear.
- R7: A non-secure request to any offset below 0xFD0 reads as zero and has no effect on any register, on the LUT or on the index.
- R8: Once lockdown is set, writes to control and to the LUT window are dropped, and a dropped LUT write does not advance the index. Index writes and auto-incrementing LUT reads still work. Only reset clears lockdown.
- R9: `size` is encoded as 0 = byte, 1 = halfword, 2 or 3 = word. The write data sits in the low bits of `wdata` and lands at byte lane `addr[1:0]`. A narrow write to control, index or window keeps the bytes it does not write.
- R10: A narrow read returns the addressed bytes right-justified in `rd_data`, with the upper bits zero.
- R11: The twelve words from 0xFD0 to 0xFFC read as the bytes 04,00,00,00,60,B8,1B,00,0D,F0,05,B1 in that order, for secure and non-secure requests alike. Writes to them are ignored.
- R12: Unmapped offsets read zero and ignore writes. `rd_data` updates only on a read request, one cycle later, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Register request, taken on each rising edge while high |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte address in the 4 KiB register window |
| size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| secure | input | 1 | Secure attribute of the request |
| wdata | input | 32 | Write data, right-justified |
| rd_data | output | 32 | Registered read data |
| lut_bits | output | LUT_WORDS*32 | Whole LUT for the filter, word i at bits 32*i and up |
| err_resp_en | output | 1 | Control bit 4: the filter answers blocked accesses with an error |
| locked | output | 1 | Control bit 31: lockdown is active |

## Verification
A wrong index is the most likely hidden fault. It shows up on `lut_bits` in the cycle after the next window write, because the wrong 32-bit slice changes. It also shows up on `rd_data` one cycle after the next window or index read. A wrong control or lockdown bit shows at once on `err_resp_en` or `locked`, and a lost merge or a bad lane shows on the next readback of that register. The bench keeps a behavioural model and compares `rd_data` and the whole LUT bus on every clock, so any divergence is reported within one cycle of the edge that caused it.

// File: rtl/secfilt_cfg_pkg.sv
package secfilt_cfg_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE     = 2'd0,
    ACC_HALF     = 2'd1,
    ACC_WORD     = 2'd2,
    ACC_WORD_ALT = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CTRL,
    RD_COUNT,
    RD_GEOM,
    RD_INDEX,
    RD_WINDOW,
    RD_IDENT
  } rd_src_e;

  // word offsets (byte offset >> 2)
  localparam logic [9:0] WO_CTRL   = 10'h000;
  localparam logic [9:0] WO_COUNT  = 10'h004;
  localparam logic [9:0] WO_GEOM   = 10'h005;
  localparam logic [9:0] WO_INDEX  = 10'h006;
  localparam logic [9:0] WO_WINDOW = 10'h007;
  localparam logic [9:0] WO_IDENT  = 10'h3F4;

  localparam int BIT_ERRRESP = 4;
  localparam int BIT_AUTOINC = 8;
  localparam int BIT_LOCK    = 31;
  localparam logic [31:0] CTRL_KEEP  = 32'h8000_0110;
  localparam logic [31:0] CTRL_RESET = 32'h0000_0100;

  function automatic logic is_full(acc_size_e sz);
    return sz[1];
  endfunction

  function automatic logic [31:0] width_mask(acc_size_e sz);
    case (sz)
      ACC_BYTE: return 32'h0000_00FF;
      ACC_HALF: return 32'h0000_FFFF;
      default:  return 32'hFFFF_FFFF;
    endcase
  endfunction

  // deposit right-justified data at the addressed lane, keep the rest
  function automatic logic [31:0] merge_word(logic [31:0] old, logic [31:0] wd,
                                             acc_size_e sz, logic [1:0] lane);
    logic [31:0] m;
    if (is_full(sz)) return wd;
    m = width_mask(sz) << {lane, 3'b000};
    return (old & ~m) | ((wd << {lane, 3'b000}) & m);
  endfunction

  function automatic logic [31:0] extract_word(logic [31:0] w, acc_size_e sz,
                                               logic [1:0] lane);
    if (is_full(sz)) return w;
    return (w >> {lane, 3'b000}) & width_mask(sz);
  endfunction

  function automatic logic [7:0] ident_byte(logic [3:0] k);
    case (k)
      4'd0:  return 8'h04;
      4'd4:  return 8'h60;
      4'd5:  return 8'hB8;
      4'd6:  return 8'h1B;
      4'd8:  return 8'h0D;
      4'd9:  return 8'hF0;
      4'd10: return 8'h05;
      4'd11: return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/secfilt_cfg_decode.sv
module secfilt_cfg_decode
  import secfilt_cfg_pkg::*;
(
  input  logic       req,
  input  logic       wr,
  input  logic [9:0] word_addr,
  input  logic       secure,
  input  logic       locked,
  output logic       ctrl_we,
  output logic       index_we,
  output logic       window_we,
  output logic       window_rd,
  output rd_src_e    rd_src,
  output logic [3:0] ident_sel
);

  logic ident_zone;
  logic wr_ok;
  logic rd_ok;

  assign ident_zone = word_addr >= WO_IDENT;
  // non-secure requests reach nothing outside the identification zone
  assign wr_ok = req && wr && secure;
  assign rd_ok = req && !wr && secure;
  assign ident_sel = word_addr[3:0] - 4'd4;

  assign ctrl_we   = wr_ok && !locked && (word_addr == WO_CTRL);
  assign window_we = wr_ok && !locked && (word_addr == WO_WINDOW);
  assign index_we  = wr_ok && (word_addr == WO_INDEX);
  assign window_rd = rd_ok && (word_addr == WO_WINDOW);

  always_comb begin
    rd_src = RD_NONE;
    if (ident_zone) begin
      rd_src = RD_IDENT;
    end else if (secure) begin
      case (word_addr)
        WO_CTRL:   rd_src = RD_CTRL;
        WO_COUNT:  rd_src = RD_COUNT;
        WO_GEOM:   rd_src = RD_GEOM;
        WO_INDEX:  rd_src = RD_INDEX;
        WO_WINDOW: rd_src = RD_WINDOW;
        default:   rd_src = RD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/secfilt_lut_bank.sv
module secfilt_lut_bank #(
  parameter int WORDS = 7,
  localparam int IDXW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  index_we,
  input  logic [31:0]           index_val,
  input  logic                  window_we,
  input  logic [31:0]           window_val,
  input  logic                  advance,
  output logic [IDXW-1:0]       index_q,
  output logic [31:0]           cur_word,
  output logic [WORDS*32-1:0]   lut_bits
);

  localparam logic [31:0]     WORDS_W = 32'(WORDS);
  localparam logic [IDXW-1:0] LAST    = IDXW'(WORDS - 1);

  logic [31:0] words [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q <= '0;
    end else if (index_we) begin
      index_q <= IDXW'(index_val % WORDS_W);
    end else if (advance) begin
      index_q <= (index_q == LAST) ? '0 : index_q + 1'b1;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        words[g] <= '0;
      end else if (window_we && (index_q == IDXW'(g))) begin
        words[g] <= window_val;
      end
    end
    assign lut_bits[g*32 +: 32] = words[g];
  end

  always_comb begin
    cur_word = '0;
    for (int i = 0; i < WORDS; i++) begin
      if (index_q == IDXW'(i)) cur_word = words[i];
    end
  end

endmodule

// File: rtl/secfilt_cfg_regs.sv
module secfilt_cfg_regs
  import secfilt_cfg_pkg::*;
#(
  parameter int NUM_BLOCKS = 200,
  parameter int BLOCK_LOG2 = 10,
  localparam int LUT_WORDS = (NUM_BLOCKS + 31) / 32,
  localparam int IDXW      = (LUT_WORDS > 1) ? $clog2(LUT_WORDS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  logic                     wr,
  input  logic [11:0]              addr,
  input  logic [1:0]               size,
  input  logic                     secure,
  input  logic [31:0]              wdata,
  output logic [31:0]              rd_data,
  output logic [LUT_WORDS*32-1:0]  lut_bits,
  output logic                     err_resp_en,
  output logic                     locked
);

  acc_size_e   sz;
  logic [1:0]  lane;
  logic [31:0] ctrl_q;
  logic        ctrl_we, index_we, window_we, window_rd;
  rd_src_e     rd_src;
  logic [3:0]  ident_sel;
  logic [IDXW-1:0] index_q;
  logic [31:0] cur_word;
  logic [31:0] index_wide;
  logic        advance;
  logic [31:0] raw;
  logic [31:0] rd_q;

  assign sz   = acc_size_e'(size);
  assign lane = addr[1:0];

  secfilt_cfg_decode u_decode (
    .req       (req),
    .wr        (wr),
    .word_addr (addr[11:2]),
    .secure    (secure),
    .locked    (ctrl_q[BIT_LOCK]),
    .ctrl_we   (ctrl_we),
    .index_we  (index_we),
    .window_we (window_we),
    .window_rd (window_rd),
    .rd_src    (rd_src),
    .ident_sel (ident_sel)
  );

  assign index_wide = 32'(index_q);
  assign advance = (window_we || window_rd) && is_full(sz) && ctrl_q[BIT_AUTOINC];

  secfilt_lut_bank #(.WORDS(LUT_WORDS)) u_lut (
    .clk        (clk),
    .rst_n      (rst_n),
    .index_we   (index_we),
    .index_val  (merge_word(index_wide, wdata, sz, lane)),
    .window_we  (window_we),
    .window_val (merge_word(cur_word, wdata, sz, lane)),
    .advance    (advance),
    .index_q    (index_q),
    .cur_word   (cur_word),
    .lut_bits   (lut_bits)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
    end else if (ctrl_we) begin
      ctrl_q <= merge_word(ctrl_q, wdata, sz, lane) & CTRL_KEEP;
    end
  end

  always_comb begin
    case (rd_src)
      RD_CTRL:   raw = ctrl_q;
      RD_COUNT:  raw = 32'(LUT_WORDS);
      RD_GEOM:   raw = 32'(BLOCK_LOG2 - 5);
      RD_INDEX:  raw = index_wide;
      RD_WINDOW: raw = cur_word;
      RD_IDENT:  raw = {24'h0, ident_byte(ident_sel)};
      default:   raw = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (req && !wr) begin
      rd_q <= extract_word(raw, sz, lane);
    end
  end

  assign rd_data     = rd_q;
  assign err_resp_en = ctrl_q[BIT_ERRRESP];
  assign locked      = ctrl_q[BIT_LOCK];

endmodule

// File: rtl/secfilt_cfg_regs_chk.sv
module secfilt_cfg_regs_chk #(
  parameter int LUT_W = 224
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic             wr,
  input logic [11:0]      addr,
  input logic [1:0]       size,
  input logic             secure,
  input logic [31:0]      rd_data,
  input logic [LUT_W-1:0] lut_bits,
  input logic             err_resp_en,
  input logic             locked
);

  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R8
  lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(lut_bits));

  // R7
  ns_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !secure && addr < 12'hFD0) |=>
      ($stable(lut_bits) && $stable(err_resp_en) && $stable(locked)));

  // R7
  ns_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !wr && !secure && addr < 12'hFD0) |=> (rd_data == 32'h0));

  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && !wr) |=> $stable(rd_data));

  // R11
  ident_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !wr && addr == 12'hFE0 && size[1]) |=> (rd_data == 32'h60));

endmodule

bind secfilt_cfg_regs secfilt_cfg_regs_chk #(.LUT_W(LUT_WORDS*32)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req         (req),
  .wr          (wr),
  .addr        (addr),
  .size        (size),
  .secure      (secure),
  .rd_data     (rd_data),
  .lut_bits    (lut_bits),
  .err_resp_en (err_resp_en),
  .locked      (locked)
);

// File: tb/secfilt_cfg_regs_tb_top.sv
`timescale 1ns/1ps
module secfilt_cfg_regs_tb_top;

  localparam int NB = 200;
  localparam int BL = 10;
  localparam int LW = (NB + 31) / 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic wr = 1'b0;
  logic [11:0] addr = '0;
  logic [1:0] size = 2'd2;
  logic secure = 1'b1;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic [LW*32-1:0] lut_bits;
  logic err_resp_en, locked;

  always #2.5 clk = ~clk;

  secfilt_cfg_regs #(.NUM_BLOCKS(NB), .BLOCK_LOG2(BL)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .size(size),
    .secure(secure), .wdata(wdata), .rd_data(rd_data), .lut_bits(lut_bits),
    .err_resp_en(err_resp_en), .locked(locked)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  logic [31:0] m_ctrl;
  int          m_idx;
  logic [31:0] m_lut [LW];
  logic [31:0] m_rd;
  logic [7:0]  id_tab [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h60, 8'hB8,
                              8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  task automatic model_reset();
    m_ctrl = 32'h100; m_idx = 0; m_rd = 0;
    for (int i = 0; i < LW; i++) m_lut[i] = 0;
  endtask

  function automatic logic [31:0] b_merge(logic [31:0] old, logic [31:0] d,
                                          logic [1:0] s, int lane);
    logic [31:0] r = old;
    int nb = (s == 2'd0) ? 1 : 2;
    if (s[1]) return d;
    for (int k = 0; k < nb; k++)
      if (lane + k < 4) r[(lane + k)*8 +: 8] = d[k*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] b_extract(logic [31:0] w, logic [1:0] s, int lane);
    logic [31:0] r = 0;
    int nb = (s == 2'd0) ? 1 : 2;
    if (s[1]) return w;
    for (int k = 0; k < nb; k++)
      if (lane + k < 4) r[k*8 +: 8] = w[(lane + k)*8 +: 8];
    return r;
  endfunction

  task automatic model_apply(bit w, logic [11:0] a, logic [1:0] s,
                             logic [31:0] d, bit sec);
    int ofs = int'(a) & 32'hFFC;
    int lane = int'(a[1:0]);
    logic [31:0] raw = 0;
    logic [31:0] nv;
    bit lk = m_ctrl[31];
    bit step = s[1] && m_ctrl[8];
    if (!sec && ofs < 'hFD0) begin
      if (!w) m_rd = 0;
      return;
    end
    if (!w) begin
      if (ofs >= 'hFD0) raw = {24'h0, id_tab[(ofs - 'hFD0) / 4]};
      else if (ofs == 'h000) raw = m_ctrl;
      else if (ofs == 'h010) raw = LW;
      else if (ofs == 'h014) raw = BL - 5;
      else if (ofs == 'h018) raw = m_idx;
      else if (ofs == 'h01C) begin
        raw = m_lut[m_idx];
        if (step) m_idx = (m_idx + 1) % LW;
      end
      m_rd = b_extract(raw, s, lane);
    end else begin
      if (ofs == 'h000 && !lk) m_ctrl = b_merge(m_ctrl, d, s, lane) & 32'h8000_0110;
      else if (ofs == 'h018) begin
        nv = b_merge(m_idx, d, s, lane);
        m_idx = int'(nv % LW);
      end else if (ofs == 'h01C && !lk) begin
        m_lut[m_idx] = b_merge(m_lut[m_idx], d, s, lane);
        if (step) m_idx = (m_idx + 1) % LW;
      end
    end
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the reference model (R5, R12)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [LW*32-1:0] flat;
      for (int i = 0; i < LW; i++) flat[i*32 +: 32] = m_lut[i];
      checks++;
      if (rd_data !== m_rd || lut_bits !== flat ||
          err_resp_en !== m_ctrl[4] || locked !== m_ctrl[31]) begin
        errors++;
        $display("FAIL R12/R5 per-cycle actual rd=%h lut=%h expected rd=%h lut=%h",
                 rd_data, lut_bits, m_rd, flat);
      end
    end
  end

  task automatic acc(bit w, logic [11:0] a, logic [1:0] s, logic [31:0] d, bit sec);
    @(negedge clk);
    req = 1'b1; wr = w; addr = a; size = s; wdata = d; secure = sec;
    @(posedge clk);
    model_apply(w, a, s, d, sec);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [1:0] s, bit sec,
                        logic [31:0] exp);
    acc(1'b0, a, s, 32'h0, sec);
    check(tag, rd_data, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 lut_bits", lut_bits[31:0] | lut_bits[LW*32-1 -: 32], 32'h0);
    check("R1 locked/err", {30'h0, locked, err_resp_en}, 32'h0);
    check("R1 rd_data", rd_data, 32'h0);
    rd_chk("R1 ctrl", 12'h000, 2'd2, 1'b1, 32'h100);
    rd_chk("R1 index", 12'h018, 2'd2, 1'b1, 32'h0);
    // R3 geometry
    rd_chk("R3 count", 12'h010, 2'd2, 1'b1, 32'(LW));
    rd_chk("R3 geom", 12'h014, 2'd2, 1'b1, 32'(BL - 5));
    acc(1'b1, 12'h010, 2'd2, 32'h55, 1'b1);
    rd_chk("R3 count after write", 12'h010, 2'd2, 1'b1, 32'(LW));
    // R2 control kept bits
    acc(1'b1, 12'h000, 2'd2, 32'h7FFF_FFFF, 1'b1);
    rd_chk("R2 ctrl mask", 12'h000, 2'd2, 1'b1, 32'h110);
    check("R2 err_resp_en", {31'h0, err_resp_en}, 32'h1);
    // R4 modulo index
    acc(1'b1, 12'h018, 2'd2, 32'd9, 1'b1);
    rd_chk("R4 index mod", 12'h018, 2'd2, 1'b1, 32'd2);
    acc(1'b1, 12'h018, 2'd2, 32'd6, 1'b1);
    // R5 window write, R6 wrap
    acc(1'b1, 12'h01C, 2'd2, 32'hA5A5_0001, 1'b1);
    check("R5 lut slice", lut_bits[6*32 +: 32], 32'hA5A5_0001);
    rd_chk("R6 wrap to 0", 12'h018, 2'd2, 1'b1, 32'd0);
    for (int i = 0; i < LW; i++) acc(1'b1, 12'h01C, 2'd2, 32'h1000_0000 + i, 1'b1);
    for (int i = 0; i < LW; i++)
      rd_chk("R5 window readback", 12'h01C, 2'd2, 1'b1, 32'h1000_0000 + i);
    rd_chk("R6 index after full sweep", 12'h018, 2'd2, 1'b1, 32'd0);
    // R9 narrow window write, R10 narrow reads, R6 no step on narrow
    acc(1'b1, 12'h018, 2'd2, 32'd2, 1'b1);
    acc(1'b1, 12'h01D, 2'd0, 32'h3C, 1'b1);
    rd_chk("R6 narrow no step", 12'h018, 2'd2, 1'b1, 32'd2);
    rd_chk("R10 half read", 12'h01E, 2'd1, 1'b1, 32'h1000);
    rd_chk("R10 byte read", 12'h01D, 2'd0, 1'b1, 32'h3C);
    rd_chk("R6 narrow read no step", 12'h018, 2'd2, 1'b1, 32'd2);
    // R9 narrow control write clears auto-increment only
    acc(1'b1, 12'h001, 2'd0, 32'h00, 1'b1);
    rd_chk("R9 ctrl merge", 12'h000, 2'd2, 1'b1, 32'h010);
    rd_chk("R9 window merged word", 12'h01C, 2'd2, 1'b1, 32'h1000_3C02);
    rd_chk("R6 autoinc off no step", 12'h018, 2'd2, 1'b1, 32'd2);
    acc(1'b1, 12'h018, 2'd1, 32'h0005, 1'b1);
    rd_chk("R9 index half write", 12'h018, 2'd2, 1'b1, 32'd5);
    // R7 non-secure isolation
    acc(1'b1, 12'h000, 2'd2, 32'h0, 1'b0);
    acc(1'b1, 12'h01C, 2'd2, 32'hDEAD, 1'b0);
    acc(1'b1, 12'h018, 2'd2, 32'd1, 1'b0);
    rd_chk("R7 ns ctrl read", 12'h000, 2'd2, 1'b0, 32'h0);
    rd_chk("R7 ctrl unchanged", 12'h000, 2'd2, 1'b1, 32'h010);
    rd_chk("R7 index unchanged", 12'h018, 2'd2, 1'b1, 32'd5);
    rd_chk("R7 lut unchanged", 12'h01C, 2'd2, 1'b1, 32'h1000_0005);
    // R11 identification
    for (int k = 0; k < 12; k++)
      rd_chk("R11 ident", 12'hFD0 + 12'(4*k), 2'd2, k[0], {24'h0, id_tab[k]});
    acc(1'b1, 12'hFE0, 2'd2, 32'hFF, 1'b1);
    rd_chk("R11 ident write ignored", 12'hFE0, 2'd2, 1'b1, 32'h60);
    rd_chk("R11 ident byte", 12'hFF4, 2'd0, 1'b0, 32'hF0);
    // R12 unmapped and hold
    acc(1'b1, 12'h024, 2'd2, 32'h1, 1'b1);
    rd_chk("R12 unmapped", 12'h024, 2'd2, 1'b1, 32'h0);
    rd_chk("R12 unmapped high", 12'h400, 2'd2, 1'b1, 32'h0);
    rd_chk("R12 count", 12'h010, 2'd2, 1'b1, 32'(LW));
    acc(1'b1, 12'h024, 2'd2, 32'h1, 1'b1);
    repeat (2) @(negedge clk);
    check("R12 rd_data hold", rd_data, 32'(LW));
    // R8 lockdown
    acc(1'b1, 12'h000, 2'd2, 32'h8000_0100, 1'b1);
    check("R8 locked out", {31'h0, locked}, 32'h1);
    acc(1'b1, 12'h018, 2'd2, 32'd3, 1'b1);
    acc(1'b1, 12'h01C, 2'd2, 32'h1234, 1'b1);
    check("R8 lut frozen", lut_bits[3*32 +: 32], 32'h1000_0003);
    rd_chk("R8 index writable, no step", 12'h018, 2'd2, 1'b1, 32'd3);
    acc(1'b1, 12'h000, 2'd2, 32'h0, 1'b1);
    rd_chk("R8 ctrl frozen", 12'h000, 2'd2, 1'b1, 32'h8000_0100);
    rd_chk("R8 read still steps", 12'h01C, 2'd2, 1'b1, 32'h1000_0003);
    rd_chk("R8 index stepped", 12'h018, 2'd2, 1'b1, 32'd4);
    do_reset();
    check("R8 reset clears lockdown", {31'h0, locked}, 32'h0);
    check("R1 lut cleared", lut_bits[3*32 +: 32], 32'h0);
    rd_chk("R1 ctrl after reset", 12'h000, 2'd2, 1'b1, 32'h100);
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule